// File: doc/BRIEF.md
# Serial Configuration Readback Engine

This block serializes the contents of a small configuration memory onto a single output bit, one bit per clock. It runs beside normal operation and does not disturb it. A low-to-high transition on the trigger input starts a pass. A busy flag then rises, and the block emits a fixed opening, every frame of the memory with forced-high padding, and a closing low bit followed by an 11-bit CRC.

The memory sits outside the block. It is read through a synchronous port that takes a frame index and a bit index and returns the stored bit one clock later. The block issues each address one cycle ahead of the bit it feeds.

An optional capture mode samples a vector of user state bits on the same clock edge that accepts the trigger. Within each frame, a fixed window of bit positions then carries the inverted snapshot instead of the memory contents. All other positions carry memory bits without inversion.

Top module: `rb_engine`

## Requirements
- R1: A synchronous reset, active high, forces `busy` low and `dout` high on the next clock edge. The reset also aborts any pass that is under way.
- R2: On a clock edge where `trig` is sampled high after being sampled low on the previous edge, and the block is idle, `busy` goes high. The first stream bit appears on `dout` at the following edge.
- R3: The stream opens with five bits at 1, followed by one bit at 0.
- R4: Frame f, position b carries the memory bit at (`rd_frame`=f, `rd_bit`=b), uninverted, unless R5–R9 say otherwise. The memory returns `rd_data` one clock after the address is presented. Frames run in order 0 to NUM_FRAMES-1, and positions in order 0 to FRAME_BITS-1.
- R5: The last four positions of every frame are 1.
- R6: Positions 0 and 1 of frame 0 are 1.
- R7: The last seven positions of the last frame are 1.
- R8: If `cap_en` is high at the accepted trigger edge, `user_state` is sampled on that edge. Frame f, position CAP_OFS+k (0 ≤ k < CAP_PER_FRAME) then carries the inverse of snapshot bit f*CAP_PER_FRAME+k. Later changes to `user_state` or `cap_en` have no effect on that pass.
- R9: If `cap_en` is low at the accepted trigger edge, those positions carry the memory bits, per R4.
- R10: After the last frame comes one bit at 0, then 11 CRC bits, most significant bit first. The CRC uses polynomial x^11+x^9+x^8+x^7+x^5+x^3+x^2+1 (mask 0x3AD), starts at zero, and covers every transmitted frame bit, shifted in MSB-first with feedback = crc[10] XOR bit.
- R11: `busy` stays high through the last CRC bit and falls on the next edge. Whenever `busy` is low, `dout` is 1.
- R12: Trigger rising edges while `busy` is high are ignored. They neither restart nor extend the pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readback clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Start request; its rising edge starts a pass |
| cap_en | input | 1 | Selects capture mode for the pass being started |
| user_state | input | NUM_FRAMES*CAP_PER_FRAME | User state bits to snapshot |
| rd_data | input | 1 | Memory read data, valid one clock after the address |
| rd_frame | output | max(1,clog2(NUM_FRAMES)) | Memory frame address |
| rd_bit | output | max(1,clog2(FRAME_BITS)) | Memory bit address within the frame |
| busy | output | 1 | Read in progress |
| dout | output | 1 | Serial stream output |

## Verification
The hardest case to reach from the ports is the snapshot's isolation from later activity. This covers `user_state` and `cap_en` changing mid-pass, and a fresh trigger edge arriving while the stream is running. The bench reaches it by flipping the user vector and the mode, and by pulsing the trigger partway through the frames. It then compares every stream bit against a sequence computed from the values present at the accepted edge. A second hard spot is a reset in the middle of the frames. The bench aborts a pass there, checks the idle outputs, and then runs a clean pass to show that no state from the aborted pass leaks into the next one.

// File: rtl/rb_pkg.sv
package rb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_FRAME,
        ST_TAIL,
        ST_CRC,
        ST_DONE
    } rb_state_e;

    localparam int CRC_W = 11;
    localparam logic [CRC_W-1:0] CRC_POLY = 11'h3AD;
    localparam int HEAD_LEN = 6;
    localparam int CHECK_BITS = 4;
    localparam int LAST_HIGH = 7;
    localparam int FIRST_HIGH = 2;
endpackage

// File: rtl/rb_crc_step.sv
module rb_crc_step #(
    parameter int W = 11,
    parameter logic [W-1:0] POLY = 11'h3AD
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;
    always_comb begin
        fb    = crc_i[W-1] ^ bit_i;
        crc_o = {crc_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
endmodule

// File: rtl/rb_frame_bit.sv
module rb_frame_bit
    import rb_pkg::*;
#(
    parameter int NUM_FRAMES    = 4,
    parameter int FRAME_BITS    = 16,
    parameter int CAP_OFS       = 4,
    parameter int CAP_PER_FRAME = 3,
    parameter int FW            = 2,
    parameter int BW            = 4,
    parameter int NCAP          = NUM_FRAMES * CAP_PER_FRAME
) (
    input  logic [FW-1:0]   frm_i,
    input  logic [BW-1:0]   pos_i,
    input  logic            cap_mode_i,
    input  logic [NCAP-1:0] snap_i,
    input  logic            mem_i,
    output logic            bit_o
);
    int  f;
    int  b;
    int  idx;
    logic in_win;
    logic sel;

    always_comb begin
        f      = int'(frm_i);
        b      = int'(pos_i);
        in_win = (b >= CAP_OFS) && (b < CAP_OFS + CAP_PER_FRAME);
        idx    = f * CAP_PER_FRAME + b - CAP_OFS;
        sel    = 1'b0;
        for (int k = 0; k < NCAP; k++) begin
            if (k == idx) sel = snap_i[k];
        end
        bit_o = mem_i;
        if (cap_mode_i && in_win) bit_o = ~sel;
        if (f == 0 && b < FIRST_HIGH) bit_o = 1'b1;
        if (f == NUM_FRAMES - 1 && b >= FRAME_BITS - LAST_HIGH) bit_o = 1'b1;
        if (b >= FRAME_BITS - CHECK_BITS) bit_o = 1'b1;
    end
endmodule

// File: rtl/rb_engine.sv
module rb_engine
    import rb_pkg::*;
#(
    parameter int NUM_FRAMES    = 4,
    parameter int FRAME_BITS    = 16,
    parameter int CAP_OFS       = 4,
    parameter int CAP_PER_FRAME = 3,
    localparam int NCAP = NUM_FRAMES * CAP_PER_FRAME,
    localparam int FW   = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int BW   = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig,
    input  logic            cap_en,
    input  logic [NCAP-1:0] user_state,
    input  logic            rd_data,
    output logic [FW-1:0]   rd_frame,
    output logic [BW-1:0]   rd_bit,
    output logic            busy,
    output logic            dout
);
    localparam int CW = (BW > 4) ? BW : 4;

    typedef struct packed {
        rb_state_e        st;
        logic [CW-1:0]    cnt;
        logic [FW-1:0]    frm;
        logic             trig_prev;
        logic             cap_mode;
        logic [NCAP-1:0]  snap;
        logic [CRC_W-1:0] crc;
        logic             busy;
        logic             dout;
    } regs_t;

    regs_t r_q, r_d;
    logic             fbit;
    logic [CRC_W-1:0] crc_nx;
    logic             rise;

    rb_frame_bit #(
        .NUM_FRAMES(NUM_FRAMES), .FRAME_BITS(FRAME_BITS), .CAP_OFS(CAP_OFS),
        .CAP_PER_FRAME(CAP_PER_FRAME), .FW(FW), .BW(BW), .NCAP(NCAP)
    ) u_sel (
        .frm_i(r_q.frm), .pos_i(r_q.cnt[BW-1:0]), .cap_mode_i(r_q.cap_mode),
        .snap_i(r_q.snap), .mem_i(rd_data), .bit_o(fbit)
    );

    rb_crc_step #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_i(r_q.crc), .bit_i(fbit), .crc_o(crc_nx)
    );

    always_comb begin
        r_d           = r_q;
        rise          = trig & ~r_q.trig_prev;
        r_d.trig_prev = trig;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.dout = 1'b1;
                r_d.busy = 1'b0;
                if (rise) begin
                    r_d.st       = ST_HEAD;
                    r_d.cnt      = '0;
                    r_d.frm      = '0;
                    r_d.busy     = 1'b1;
                    r_d.cap_mode = cap_en;
                    r_d.snap     = user_state;
                end
            end
            ST_HEAD: begin
                r_d.dout = (int'(r_q.cnt) != HEAD_LEN - 1);
                if (int'(r_q.cnt) == HEAD_LEN - 1) begin
                    r_d.crc = '0;
                    r_d.st  = ST_FRAME;
                    r_d.cnt = '0;
                    r_d.frm = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_FRAME: begin
                r_d.dout = fbit;
                r_d.crc  = crc_nx;
                if (int'(r_q.cnt) == FRAME_BITS - 1) begin
                    r_d.cnt = '0;
                    if (int'(r_q.frm) == NUM_FRAMES - 1) r_d.st = ST_TAIL;
                    else r_d.frm = r_q.frm + 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_TAIL: begin
                r_d.dout = 1'b0;
                r_d.st   = ST_CRC;
                r_d.cnt  = '0;
            end
            ST_CRC: begin
                r_d.dout = r_q.crc[CRC_W-1];
                r_d.crc  = {r_q.crc[CRC_W-2:0], 1'b0};
                if (int'(r_q.cnt) == CRC_W - 1) r_d.st = ST_DONE;
                else r_d.cnt = r_q.cnt + 1'b1;
            end
            default: begin
                r_d.dout = 1'b1;
                r_d.busy = 1'b0;
                r_d.st   = ST_IDLE;
            end
        endcase
        if (rst) begin
            r_d           = '0;
            r_d.st        = ST_IDLE;
            r_d.dout      = 1'b1;
            r_d.trig_prev = trig;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign rd_frame = r_d.frm;
    assign rd_bit   = (r_d.st == ST_FRAME) ? r_d.cnt[BW-1:0] : '0;
    assign busy     = r_q.busy;
    assign dout     = r_q.dout;
endmodule

// File: rtl/rb_engine_chk.sv
module rb_engine_chk #(
    parameter int NUM_FRAMES = 4,
    parameter int FRAME_BITS = 16,
    parameter int FW = 2,
    parameter int BW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          trig,
    input logic          busy,
    input logic          dout,
    input logic [FW-1:0] rd_frame,
    input logic [BW-1:0] rd_bit
);
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!busy && dout))
        else $error("a_r1_reset_idle");

    a_r2_busy_on_edge: assert property (@(posedge clk) disable iff (rst)
        (!busy && trig && !$past(trig)) |=> busy)
        else $error("a_r2_busy_on_edge");

    a_r3_first_dummy_high: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> dout)
        else $error("a_r3_first_dummy_high");

    a_r11_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> dout)
        else $error("a_r11_idle_high");

    a_r4_addr_range: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_bit) < FRAME_BITS) && (int'(rd_frame) < NUM_FRAMES))
        else $error("a_r4_addr_range");
endmodule

bind rb_engine rb_engine_chk #(
    .NUM_FRAMES(NUM_FRAMES), .FRAME_BITS(FRAME_BITS), .FW(FW), .BW(BW)
) u_chk (
    .clk(clk), .rst(rst), .trig(trig), .busy(busy), .dout(dout),
    .rd_frame(rd_frame), .rd_bit(rd_bit)
);

// File: tb/sim_rb_engine.sv
module sim_rb_engine;
    localparam int NF = 4, FB = 16, CO = 4, CP = 3, NC = NF * CP;
    localparam int FW = 2, BW = 4, HL = 6;
    localparam int N = HL + NF * FB + 1 + 11;

    logic clk = 1'b0, rst = 1'b1, trig = 1'b0, cap_en = 1'b0;
    logic [NC-1:0] user_state = '0;
    logic rd_data = 1'b0;
    logic [FW-1:0] rd_frame;
    logic [BW-1:0] rd_bit;
    logic busy, dout;
    int seed = 0;
    int checks = 0, errors = 0;
    logic exp_s [N];

    always #4 clk = ~clk;

    rb_engine #(.NUM_FRAMES(NF), .FRAME_BITS(FB), .CAP_OFS(CO), .CAP_PER_FRAME(CP)) u0 (
        .clk(clk), .rst(rst), .trig(trig), .cap_en(cap_en), .user_state(user_state),
        .rd_data(rd_data), .rd_frame(rd_frame), .rd_bit(rd_bit), .busy(busy), .dout(dout)
    );

    function automatic logic memfn(int f, int b, int s);
        return 1'(((f * 13 + b * 7 + s * 5 + f * b * 3) >> 1) & 1);
    endfunction

    always @(posedge clk) rd_data <= memfn(int'(rd_frame), int'(rd_bit), seed);

    task automatic check(string tag, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, expv);
        end
    endtask

    function automatic string tag_of(int i, logic cap);
        int f, b;
        if (i < HL) return "R3";
        if (i >= HL + NF * FB) return "R10";
        f = (i - HL) / FB;
        b = (i - HL) % FB;
        if (b >= FB - 4) return "R5";
        if (f == NF - 1 && b >= FB - 7) return "R7";
        if (f == 0 && b < 2) return "R6";
        if (b >= CO && b < CO + CP) return cap ? "R8" : "R9";
        return "R4";
    endfunction

    task automatic build(logic cap, logic [NC-1:0] snap);
        logic [10:0] crc = '0;
        logic fbk, v;
        for (int i = 0; i < HL; i++) exp_s[i] = (i != HL - 1);
        for (int f = 0; f < NF; f++) begin
            for (int b = 0; b < FB; b++) begin
                v = memfn(f, b, seed);
                if (cap && b >= CO && b < CO + CP) v = ~snap[f * CP + b - CO];
                if (f == 0 && b < 2) v = 1'b1;
                if (f == NF - 1 && b >= FB - 7) v = 1'b1;
                if (b >= FB - 4) v = 1'b1;
                exp_s[HL + f * FB + b] = v;
                fbk = crc[10] ^ v;
                crc = {crc[9:0], 1'b0} ^ (fbk ? 11'h3AD : 11'h000);
            end
        end
        exp_s[HL + NF * FB] = 1'b0;
        for (int k = 0; k < 11; k++) exp_s[HL + NF * FB + 1 + k] = crc[10 - k];
    endtask

    task automatic run(logic cap, logic [NC-1:0] snap, bit disturb, int abort_at);
        build(cap, snap);
        @(negedge clk);
        cap_en = cap; user_state = snap; trig = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 busy before edge", busy, 1'b0);
        trig = 1'b1;
        @(negedge clk);
        check("R2 busy after edge", busy, 1'b1);
        if (disturb) begin
            user_state = ~snap;
            cap_en = ~cap;
        end
        trig = 1'b0;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            if (disturb && i == 10) trig = 1'b1;
            if (disturb && i == 12) trig = 1'b0;
            if (disturb && i == 40) trig = 1'b1;
            if (i == abort_at) begin
                rst = 1'b1;
                @(negedge clk);
                check("R1 abort busy", busy, 1'b0);
                check("R1 abort dout", dout, 1'b1);
                rst = 1'b0; trig = 1'b0;
                return;
            end
            check(tag_of(i, cap), dout, exp_s[i]);
            check("R11 busy during stream", busy, 1'b1);
        end
        @(negedge clk);
        check("R11 busy falls", busy, 1'b0);
        check("R11 idle dout", dout, 1'b1);
        trig = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R12 no restart", busy, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset busy", busy, 1'b0);
        check("R1 reset dout", dout, 1'b1);
        rst = 1'b0;
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 2; c++) begin
                seed = s;
                run(c[0], NC'(s * 32'h5A3 ^ 32'hA5C ^ c * 32'h3C), s[0], -1);
            end
        end
        seed = 2;
        run(1'b1, NC'(32'h6E1), 1'b0, 30);
        run(1'b1, NC'(32'h193), 1'b1, -1);
        run(1'b0, '1, 1'b0, -1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule